// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an asynchronous static RAM whose 16-bit data bus is split into a lower and an upper byte lane. The host issues one request at a time through a valid/ready handshake. Each request carries an address, a write flag, write data and two byte enables. The block turns it into a strobe sequence on the memory pins: two chip selects of opposite polarity, a write enable, an output enable and one strobe per byte lane. Read data returns to the host with a single-cycle valid pulse.

Every phase length comes from a nanosecond parameter. The block rounds it up to whole clock periods, so the same RTL serves a faster or a slower memory grade by changing parameters only. A write keeps write enable low for the longest of three limits: cycle time, pulse width and data-to-end overlap. It then keeps driving data for one extra cycle. A read keeps output enable low for the longer of cycle time and output-enable access time. After a read, the block waits a turnaround period so that the memory's output drivers have released the bus before the controller drives it again.

The memory data bus is modelled as separate output, output-enable and input signals.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high, and on the cycle after it, the outputs are idle: `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_lb_n`=1, `mem_ub_n`=1, `mem_dq_oe`=0, `req_ready`=1, `rsp_valid`=0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the sequence, including any turnaround, has finished.
- R3: A write holds `mem_cs1_n`=0, `mem_cs2`=1 and `mem_we_n`=0 with `mem_oe_n`=1 for exactly WR cycles, where WR = max(cyc(T_RC_NS), cyc(T_WP_NS), cyc(T_DW_NS)). `mem_addr` stays stable throughout.
- R4: During every write-enable-low cycle, and for the one cycle after `mem_we_n` rises, `mem_dq_oe`=1 and `mem_dq_out` equals the request's write data.
- R5: A read holds `mem_cs1_n`=0, `mem_cs2`=1 and `mem_oe_n`=0 with `mem_we_n`=1 and `mem_dq_oe`=0 for exactly RD cycles, where RD = max(cyc(T_RC_NS), cyc(T_OE_NS)).
- R6: Read data is sampled from `mem_dq_in` on the last clock edge with `mem_oe_n`=0. It appears on `rsp_rdata` with `rsp_valid`=1 for exactly one cycle, directly after that edge, and read responses come back in request order.
- R7: After `mem_oe_n` rises, `mem_dq_oe` stays 0 for at least cyc(T_HZ_NS) cycles.
- R8: During an access, `mem_lb_n` = NOT `req_be[0]` and `mem_ub_n` = NOT `req_be[1]`, using the byte enables of that request. A request with `req_be`=2'b00 asserts no lane strobe, and a write with `req_be`=2'b00 leaves memory unchanged.
- R9: cyc(t) = ceil(t / CLK_NS) for t > 0, and 0 for t = 0. For example, 55 ns at a 10 ns clock gives 6 cycles.
- R10: `mem_cs1_n` is always the complement of `mem_cs2`. The chip is either selected through both pins or through neither.
- R11: A lane strobe or `mem_we_n` is low only while the chip is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 16 | Data returned from memory |

## Verification
The bench builds the controller with a 10 ns clock and the slower grade's timings: 55 ns cycle, 40 ns write pulse, 25 ns data overlap, 35 ns output-enable access and 20 ns release. These values do not divide evenly by the clock period, so ceiling rounding is visible (55 ns becomes 6 cycles, not 5). The write pulse is set by cycle time rather than pulse width, and the release needs two cycles, so back-to-back read-then-write traffic tests the turnaround. Partial-lane writes, a write with no byte enables and single-lane reads against a bench memory model cover the lane strobe mapping.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_WHOLD = 3'd2,
        ST_READ  = 3'd3,
        ST_TURN  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic             cs1_n;
        logic             cs2;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] lane_n;
        logic             dq_oe;
    } pin_set_t;

    localparam pin_set_t PINS_IDLE = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1,
                                       oe_n: 1'b1, lane_n: '1, dq_oe: 1'b0};

    // Round a nanosecond figure up to whole clock periods; zero stays zero.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        if (t_ns <= 0) return 0;
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq import sram_ctrl_pkg::*; #(
    parameter int CNT_W  = 3,
    parameter int WR_CYC = 1,
    parameter int RD_CYC = 1,
    parameter int HZ_CYC = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic             done,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             capture,
    output seq_state_e       state_q,
    output seq_state_e       state_n
);
    always_comb begin
        state_n  = state_q;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                load = 1'b1;
                if (req_we) begin
                    state_n  = ST_WRITE;
                    load_val = CNT_W'(WR_CYC - 1);
                end else begin
                    state_n  = ST_READ;
                    load_val = CNT_W'(RD_CYC - 1);
                end
            end
            ST_WRITE: if (done) state_n = ST_WHOLD;
            ST_WHOLD: state_n = ST_IDLE;
            ST_READ: if (done) begin
                capture = 1'b1;
                if (HZ_CYC > 0) begin
                    state_n  = ST_TURN;
                    load     = 1'b1;
                    load_val = CNT_W'((HZ_CYC > 0) ? HZ_CYC - 1 : 0);
                end else begin
                    state_n = ST_IDLE;
                end
            end
            ST_TURN: if (done) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map import sram_ctrl_pkg::*; (
    input  logic             en,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] lane_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_n[i] = ~(en & be[i]);
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl import sram_ctrl_pkg::*; #(
    parameter int ADDR_W  = 18,
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 45,
    parameter int T_WP_NS = 35,
    parameter int T_DW_NS = 25,
    parameter int T_OE_NS = 30,
    parameter int T_HZ_NS = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);
    localparam int RC_CYC = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int WP_CYC = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int DW_CYC = ns_to_cyc(T_DW_NS, CLK_NS);
    localparam int OE_CYC = ns_to_cyc(T_OE_NS, CLK_NS);
    localparam int HZ_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int WR_CYC = max3(RC_CYC, WP_CYC, (DW_CYC > 0) ? DW_CYC : 1);
    localparam int RD_CYC = max3(RC_CYC, OE_CYC, 1);
    localparam int MAXC   = max3(WR_CYC, RD_CYC, HZ_CYC);
    localparam int CNT_W  = $clog2(MAXC + 1);

    seq_state_e       state_q, state_n;
    logic             ld, done, capture, accept;
    logic [CNT_W-1:0] ld_val;
    logic [LANES-1:0] be_q, be_sel, lane_n_nxt;
    pin_set_t         pins_q, pins_n;
    logic             rvalid_q;
    logic [DATA_W-1:0] rdata_q, wdata_q;
    logic [ADDR_W-1:0] addr_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    sram_seq #(
        .CNT_W (CNT_W),
        .WR_CYC(WR_CYC),
        .RD_CYC(RD_CYC),
        .HZ_CYC(HZ_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_we   (req_we),
        .done     (done),
        .load     (ld),
        .load_val (ld_val),
        .capture  (capture),
        .state_q  (state_q),
        .state_n  (state_n)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (ld),
        .load_val(ld_val),
        .done    (done)
    );

    assign be_sel = accept ? req_be : be_q;

    sram_lane_map u_lanes (
        .en    (1'b1),
        .be    (be_sel),
        .lane_n(lane_n_nxt)
    );

    // Pins are decoded from the next state and registered, so no strobe glitches.
    always_comb begin
        pins_n = PINS_IDLE;
        case (state_n)
            ST_WRITE: begin
                pins_n.cs1_n  = 1'b0;
                pins_n.cs2    = 1'b1;
                pins_n.we_n   = 1'b0;
                pins_n.lane_n = lane_n_nxt;
                pins_n.dq_oe  = 1'b1;
            end
            ST_WHOLD: pins_n.dq_oe = 1'b1;
            ST_READ: begin
                pins_n.cs1_n  = 1'b0;
                pins_n.cs2    = 1'b1;
                pins_n.oe_n   = 1'b0;
                pins_n.lane_n = lane_n_nxt;
            end
            default: pins_n = PINS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q   <= PINS_IDLE;
            be_q     <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            pins_q   <= pins_n;
            rvalid_q <= capture;
            if (capture) rdata_q <= mem_dq_in;
            if (accept) begin
                be_q    <= req_be;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_cs1_n  = pins_q.cs1_n;
    assign mem_cs2    = pins_q.cs2;
    assign mem_we_n   = pins_q.we_n;
    assign mem_oe_n   = pins_q.oe_n;
    assign mem_lb_n   = pins_q.lane_n[0];
    assign mem_ub_n   = pins_q.lane_n[1];
    assign mem_dq_oe  = pins_q.dq_oe;
    assign rsp_valid  = rvalid_q;
    assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int HZ_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              mem_dq_oe
);
    logic              sel_prev;
    logic [ADDR_W-1:0] addr_prev;
    int unsigned       gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev  <= 1'b0;
            addr_prev <= '0;
            gap_q     <= HZ_CYC;
        end else begin
            sel_prev  <= !mem_cs1_n;
            addr_prev <= mem_addr;
            if (!mem_oe_n)          gap_q <= 0;
            else if (gap_q < HZ_CYC) gap_q <= gap_q + 1;
        end
    end

    // R10
    cs_pair_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cs1_n == !mem_cs2);

    // R11
    strobe_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_lb_n || !mem_ub_n) |-> !mem_cs1_n);

    // R3
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R5
    oe_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_cs1_n |-> !req_ready);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs1_n && sel_prev) |-> (mem_addr == addr_prev));

    // R6
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R7
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (gap_q >= HZ_CYC));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .HZ_CYC(HZ_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_cs1_n(mem_cs1_n),
    .mem_cs2  (mem_cs2),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_lb_n (mem_lb_n),
    .mem_ub_n (mem_ub_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
    localparam int AW = 8;
    // Slow grade at 10 ns: ceil(55/10)=6, ceil(40/10)=4, ceil(25/10)=3,
    // ceil(35/10)=4, ceil(20/10)=2
    localparam int WR_EXP = 6;
    localparam int RD_EXP = 6;
    localparam int HZ_EXP = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_we = 1'b0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_be = '0;
    logic          rsp_valid;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0]   mem_dq_out, mem_dq_in;
    logic          mem_dq_oe;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    logic [15:0] model [0:255];
    logic [15:0] shadow [0:255];
    logic [15:0] exp_q [$];
    logic [1:0]  cur_be = '0;
    logic [15:0] cur_wdata = '0;

    always #5 clk = ~clk;

    sram_ctrl #(
        .ADDR_W(AW), .CLK_NS(10), .T_RC_NS(55), .T_WP_NS(40),
        .T_DW_NS(25), .T_OE_NS(35), .T_HZ_NS(20)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: drives strobed lanes during a read, stores strobed lanes during a write.
    always_comb begin
        mem_dq_in = 16'h0000;
        if (!mem_cs1_n && mem_cs2 && !mem_oe_n) begin
            if (!mem_lb_n) mem_dq_in[7:0]  = model[mem_addr][7:0];
            if (!mem_ub_n) mem_dq_in[15:8] = model[mem_addr][15:8];
        end
    end

    always @(posedge clk) begin
        if (!mem_cs1_n && mem_cs2 && !mem_we_n && mem_dq_oe) begin
            if (!mem_lb_n) model[mem_addr][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) model[mem_addr][15:8] <= mem_dq_out[15:8];
        end
    end

    // Monitor: pulse lengths, data drive, lane strobes, turnaround, scoreboard.
    int  we_cnt = 0, oe_cnt = 0, gap = 0;
    bit  drive_ok = 1'b1, gap_armed = 1'b0, prev_oe_low = 1'b0, prev_rv = 1'b0;
    bit  prev_sel = 1'b0;
    bit  [1:0] seen = 2'b00;
    int  cs_bad = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_cs1_n != !mem_cs2) cs_bad++;
            if (!mem_cs1_n) begin
                if (!mem_lb_n) seen[0] = 1'b1;
                if (!mem_ub_n) seen[1] = 1'b1;
            end
            if (prev_sel && mem_cs1_n) begin
                // R8 lane strobes follow byte enables
                check(seen == cur_be, "R8", "lane strobes seen", seen, cur_be);
                seen = 2'b00;
            end
            prev_sel = !mem_cs1_n;

            if (!mem_we_n) begin
                we_cnt++;
                if (!(mem_dq_oe && mem_dq_out == cur_wdata)) drive_ok = 1'b0;
            end else if (we_cnt > 0) begin
                // R3 R9 write pulse length
                check(we_cnt == WR_EXP, "R3", "write pulse cycles", we_cnt, WR_EXP);
                // R4 data driven through pulse and one cycle after
                check(drive_ok && mem_dq_oe && mem_dq_out == cur_wdata, "R4",
                      "write data drive", mem_dq_oe, 1);
                we_cnt = 0;
                drive_ok = 1'b1;
            end

            if (!mem_oe_n) begin
                oe_cnt++;
            end else if (oe_cnt > 0) begin
                // R5 R9 read access length
                check(oe_cnt == RD_EXP, "R5", "read oe cycles", oe_cnt, RD_EXP);
                oe_cnt = 0;
            end

            if (prev_oe_low && mem_oe_n) begin
                gap_armed = 1'b1;
                gap = 0;
            end
            if (gap_armed) begin
                if (mem_dq_oe) begin
                    // R7 bus release before driving
                    check(gap >= HZ_EXP, "R7", "turnaround cycles", gap, HZ_EXP);
                    gap_armed = 1'b0;
                end else begin
                    gap++;
                end
            end
            prev_oe_low = !mem_oe_n;

            if (prev_rv) begin
                // R6 single-cycle valid
                check(!rsp_valid, "R6", "rsp_valid pulse width", rsp_valid, 0);
            end
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected response", rsp_rdata, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rsp_rdata == e, "R6", "read data", rsp_rdata, e);
                end
            end
            prev_rv = rsp_valid;
        end
    end

    task automatic issue(input bit we, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        cur_be    = be;
        cur_wdata = d;
        if (we) begin
            if (be[0]) shadow[a][7:0]  = d[7:0];
            if (be[1]) shadow[a][15:8] = d[15:8];
        end else begin
            exp_q.push_back({be[1] ? shadow[a][15:8] : 8'h00,
                             be[0] ? shadow[a][7:0]  : 8'h00});
        end
        @(negedge clk);
        req_valid = 1'b0;
        // R2 ready drops once accepted
        check(!req_ready, "R2", "ready after accept", req_ready, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            model[i]  = 16'h0000;
            shadow[i] = 16'h0000;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check({mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n,
               mem_dq_oe, req_ready, rsp_valid} == 9'b101111010, "R1",
              "pins in reset",
              {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n,
               mem_dq_oe, req_ready, rsp_valid}, 9'b101111010);
        rst = 1'b0;
        @(negedge clk);
        check(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe &&
              req_ready && !rsp_valid, "R1", "pins after reset", mem_cs1_n, 1);

        issue(1'b1, 8'h10, 16'h1234, 2'b11);
        issue(1'b0, 8'h10, 16'h0000, 2'b11);
        issue(1'b1, 8'h11, 16'hABCD, 2'b01);   // lower lane only
        issue(1'b0, 8'h11, 16'h0000, 2'b11);
        issue(1'b1, 8'h11, 16'hEF00, 2'b10);   // upper lane only
        issue(1'b0, 8'h11, 16'h0000, 2'b11);
        // R8 write with no enables leaves memory unchanged
        issue(1'b1, 8'h10, 16'hFFFF, 2'b00);
        issue(1'b0, 8'h10, 16'h0000, 2'b11);
        issue(1'b0, 8'h10, 16'h0000, 2'b01);
        issue(1'b0, 8'h10, 16'h0000, 2'b10);
        issue(1'b0, 8'h10, 16'h0000, 2'b00);
        for (int k = 0; k < 6; k++)
            issue(1'b1, 8'(8'h40 + k), 16'(16'h5A00 + k * 16'h0111), 2'b11);
        for (int k = 0; k < 6; k++) begin
            issue(1'b0, 8'(8'h40 + k), 16'h0000, 2'b11);
            issue(1'b1, 8'(8'h80 + k), 16'(16'hC3C3 ^ k), 2'(k % 4));
        end
        for (int k = 0; k < 6; k++)
            issue(1'b0, 8'(8'h80 + k), 16'h0000, 2'b11);
        repeat (20) @(negedge clk);
        // R6 every read answered
        check(exp_q.size() == 0, "R6", "pending responses", exp_q.size(), 0);
        // R10 chip selects complementary
        check(cs_bad == 0, "R10", "cs polarity mismatches", cs_bad, 0);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule